// File: doc/BRIEF.md
# Per-Channel Colour Remap Table with In-Band Loading

This block remaps each pixel of a 24-bit video stream through three 256-entry by 8-bit tables, one each for red, green and blue. A typical use is gamma correction. In the default mode each colour component addresses its own table. In indexed-colour mode the low byte of the pixel addresses all three tables at once, so one palette index yields a full RGB value. A bypass bit passes pixels through unchanged. Valid, vertical-sync, line-start and active-video flags travel with the data through the one-cycle lookup, so they stay aligned with it.

The tables can be loaded in two ways, chosen by a mode bit. The first is a host write port with a table select, an entry address and a data byte. The second is in-band capture from the pixel stream itself. In that mode the block counts lines from vertical sync and bytes from the start of the frame. It captures 768 bytes, taken from the low byte of each valid sample, from a window that opens on the first sample of the line two lines above the programmed first active line. The bytes arrive grouped per entry: red, then green, then blue for entry 0, then the same for entry 1, and so on. With 512 samples per line, the 768 bytes end halfway through the line just above the first active line.

Top module: `rgb_gamma_lut`

## Requirements
- R1: While rst_n is low, out_vld, out_vs, out_hs and out_de are all 0.
- R2: out_vld, out_vs, out_hs and out_de equal pix_vld, pix_vs, pix_hs and pix_de from one clock earlier.
- R3: With bypass and indexed mode both off, out_data[23:16], out_data[15:8] and out_data[7:0] are, one cycle after the input, the red table at pix_data[23:16], the green table at pix_data[15:8] and the blue table at pix_data[7:0].
- R4: With indexed mode on and bypass off, pix_data[7:0] addresses all three tables. The output is {red[idx], green[idx], blue[idx]} one cycle later.
- R5: With cfg_bypass high, out_data equals pix_data from one cycle earlier. Bypass takes priority over indexed mode.
- R6: In host mode (cfg_inband_en = 0), a host write stores host_wdata at host_addr in the red table when host_sel = 0, in the green table when host_sel = 1 and in the blue table when host_sel = 2. When host_sel = 3, nothing is written. At most one table is written per cycle.
- R7: With cfg_inband_en = 1, host writes have no effect on any table.
- R8: A table write and a lookup of the same entry in the same cycle return the newly written value (write-first).
- R9: With cfg_inband_en = 1, in-band capture takes pix_data[7:0] of each valid sample. Capture starts at the first sample of line cfg_first_line-2. Line 0 is the sample with pix_vs = 1, and each later pix_hs = 1 sample starts the next line. Byte k is written to table k mod 3 (0 = red, 1 = green, 2 = blue) at entry k/3.
- R10: In-band capture stops after 768 bytes, or when line cfg_first_line begins, whichever comes first. Later bytes in the window do not change any table. pix_vs restarts the count.
- R11: With cfg_inband_en = 0, stream contents never write any table.
- R12: Samples with pix_vld = 0 are ignored by the line and byte counters and are never captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypass | input | 1 | Pass pixels through unchanged |
| cfg_indexed | input | 1 | Low byte indexes all three tables |
| cfg_inband_en | input | 1 | 1: load from the stream, 0: load from the host port |
| cfg_first_line | input | 12 | Number of the first active line (at least 2) |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Table select: 0 red, 1 green, 2 blue, 3 none |
| host_addr | input | 8 | Table entry address |
| host_wdata | input | 8 | Entry value |
| pix_vld | input | 1 | Input sample valid |
| pix_vs | input | 1 | First sample of a frame |
| pix_hs | input | 1 | First sample of a line |
| pix_de | input | 1 | Active-video flag |
| pix_data | input | 24 | Pixel {R, G, B} |
| out_vld | output | 1 | Output sample valid |
| out_vs | output | 1 | Delayed pix_vs |
| out_hs | output | 1 | Delayed pix_hs |
| out_de | output | 1 | Delayed pix_de |
| out_data | output | 24 | Remapped pixel {R, G, B} |

## Verification
Every output is due exactly one rising edge after the input cycle that produced it. The bench drives inputs on the falling edge and samples outputs 2 ns after the next rising edge, then compares them against a reference computed from that input alone. Table writes, from the host or in-band, take effect at the same edge as a lookup of that edge. The reference model therefore applies each write before it computes the expected output of that cycle, which also checks the write-first collision case. After each in-band frame the bench reads back every entry through lookups in the following cycles.

// File: rtl/rgb_gamma_lut_pkg.sv
package rgb_gamma_lut_pkg;

    localparam int unsigned NUM_TABLES = 3;

    // Table identifiers; the numbering is the in-band byte order within an entry
    typedef enum logic [1:0] {
        TBL_RED   = 2'd0,
        TBL_GREEN = 2'd1,
        TBL_BLUE  = 2'd2,
        TBL_NONE  = 2'd3
    } tbl_sel_e;

endpackage

// File: rtl/lut_ram.sv
// Single table: one write port, one registered read port, write-first on collision.
module lut_ram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = mem[raddr];
        if (we && (waddr == raddr)) begin
            rd_d = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rd_q <= rd_d;
    end

    assign rdata = rd_q;
endmodule

// File: rtl/lut_inband_loader.sv
// Tracks line number and capture position; emits one table write per captured byte.
module lut_inband_loader
    import rgb_gamma_lut_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [LW-1:0] first_line,
    input  logic          pix_vld,
    input  logic          pix_vs,
    input  logic          pix_hs,
    input  logic [DW-1:0] pix_byte,
    output logic          ld_we,
    output tbl_sel_e      ld_sel,
    output logic [DW-1:0] ld_addr,
    output logic [DW-1:0] ld_data
);
    localparam logic [DW-1:0] LAST_ENTRY = {DW{1'b1}};

    typedef struct packed {
        logic [LW-1:0] line;
        logic [DW-1:0] entry;
        logic [1:0]    phase;
        logic          full;
    } ld_state_t;

    ld_state_t st_d, st_q;

    logic [LW-1:0] cur_line;
    logic [DW-1:0] base_entry;
    logic [1:0]    base_phase;
    logic          base_full;
    logic          in_win;

    always_comb begin
        st_d = st_q;

        cur_line   = pix_vs ? '0 : (pix_hs ? st_q.line + LW'(1) : st_q.line);
        base_entry = pix_vs ? '0 : st_q.entry;
        base_phase = pix_vs ? '0 : st_q.phase;
        base_full  = pix_vs ? 1'b0 : st_q.full;

        in_win = pix_vld && en && !base_full &&
                 ((cur_line == first_line - LW'(2)) || (cur_line == first_line - LW'(1)));

        ld_we   = in_win;
        ld_sel  = tbl_sel_e'(base_phase);
        ld_addr = base_entry;
        ld_data = pix_byte;

        if (pix_vld) begin
            st_d.line  = cur_line;
            st_d.entry = base_entry;
            st_d.phase = base_phase;
            st_d.full  = base_full;
            if (in_win) begin
                if (base_phase == 2'd2) begin
                    st_d.phase = 2'd0;
                    if (base_entry == LAST_ENTRY) begin
                        st_d.full = 1'b1;
                    end else begin
                        st_d.entry = base_entry + DW'(1);
                    end
                end else begin
                    st_d.phase = base_phase + 2'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rgb_gamma_lut.sv
module rgb_gamma_lut
    import rgb_gamma_lut_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned LW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_bypass,
    input  logic            cfg_indexed,
    input  logic            cfg_inband_en,
    input  logic [LW-1:0]   cfg_first_line,
    input  logic            host_we,
    input  logic [1:0]      host_sel,
    input  logic [DW-1:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    input  logic            pix_vld,
    input  logic            pix_vs,
    input  logic            pix_hs,
    input  logic            pix_de,
    input  logic [3*DW-1:0] pix_data,
    output logic            out_vld,
    output logic            out_vs,
    output logic            out_hs,
    output logic            out_de,
    output logic [3*DW-1:0] out_data
);
    localparam int unsigned PW = NUM_TABLES * DW;

    typedef struct packed {
        logic          vld;
        logic          vs;
        logic          hs;
        logic          de;
        logic          byp;
        logic [PW-1:0] raw;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic          ld_we;
    tbl_sel_e      ld_sel;
    logic [DW-1:0] ld_addr, ld_data;

    logic [NUM_TABLES-1:0] tbl_we;
    logic [DW-1:0]         tbl_rd [NUM_TABLES];

    lut_inband_loader #(.DW(DW), .LW(LW)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_inband_en),
        .first_line (cfg_first_line),
        .pix_vld    (pix_vld),
        .pix_vs     (pix_vs),
        .pix_hs     (pix_hs),
        .pix_byte   (pix_data[DW-1:0]),
        .ld_we      (ld_we),
        .ld_sel     (ld_sel),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data)
    );

    for (genvar k = 0; k < NUM_TABLES; k++) begin : g_tbl
        logic [DW-1:0] raddr, waddr, wdata;

        // Table 0 (red) sits in the top byte of the pixel
        assign raddr = cfg_indexed ? pix_data[DW-1:0]
                                   : pix_data[(NUM_TABLES-1-k)*DW +: DW];
        assign tbl_we[k] = cfg_inband_en ? (ld_we && (ld_sel == tbl_sel_e'(k)))
                                         : (host_we && (host_sel == 2'(k)));
        assign waddr = cfg_inband_en ? ld_addr : host_addr;
        assign wdata = cfg_inband_en ? ld_data : host_wdata;

        lut_ram #(.AW(DW), .DW(DW)) u_ram (
            .clk   (clk),
            .we    (tbl_we[k]),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (raddr),
            .rdata (tbl_rd[k])
        );
    end

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.vld = pix_vld;
        pipe_d.vs  = pix_vs;
        pipe_d.hs  = pix_hs;
        pipe_d.de  = pix_de;
        pipe_d.byp = cfg_bypass;
        pipe_d.raw = pix_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_vld  = pipe_q.vld;
    assign out_vs   = pipe_q.vs;
    assign out_hs   = pipe_q.hs;
    assign out_de   = pipe_q.de;
    assign out_data = pipe_q.byp ? pipe_q.raw : {tbl_rd[0], tbl_rd[1], tbl_rd[2]};
endmodule

// File: rtl/rgb_gamma_lut_chk.sv
module rgb_gamma_lut_chk #(
    parameter int unsigned DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_bypass,
    input logic            cfg_inband_en,
    input logic            host_we,
    input logic            pix_vld,
    input logic            pix_vs,
    input logic            pix_hs,
    input logic            pix_de,
    input logic [3*DW-1:0] pix_data,
    input logic            out_vld,
    input logic            out_vs,
    input logic            out_hs,
    input logic            out_de,
    input logic [3*DW-1:0] out_data,
    input logic [2:0]      tbl_we
);
    localparam int unsigned TOTAL = 3 * (1 << DW);
    localparam int unsigned CW    = $clog2(TOTAL + 1) + 1;

    logic [CW-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = pix_vld && pix_vs ? '0 : cap_q;
        if (cfg_inband_en && (|tbl_we)) begin
            cap_d = cap_d + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && !out_vs && !out_hs && !out_de));

    a_r2_flags_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({out_vld, out_vs, out_hs, out_de} ==
                  $past({pix_vld, pix_vs, pix_hs, pix_de})));

    a_r5_bypass_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bypass |=> (out_data == $past(pix_data)));

    a_r6_single_table_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tbl_we));

    a_r7_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_inband_en && !pix_vld) |-> (tbl_we == 3'b000));

    a_r11_stream_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_inband_en && !host_we) |-> (tbl_we == 3'b000));

    a_r10_capture_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q <= CW'(TOTAL));
endmodule

bind rgb_gamma_lut rgb_gamma_lut_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_bypass    (cfg_bypass),
    .cfg_inband_en (cfg_inband_en),
    .host_we       (host_we),
    .pix_vld       (pix_vld),
    .pix_vs        (pix_vs),
    .pix_hs        (pix_hs),
    .pix_de        (pix_de),
    .pix_data      (pix_data),
    .out_vld       (out_vld),
    .out_vs        (out_vs),
    .out_hs        (out_hs),
    .out_de        (out_de),
    .out_data      (out_data),
    .tbl_we        (tbl_we)
);

// File: tb/sim_rgb_gamma_lut.sv
`timescale 1ns/1ps
module sim_rgb_gamma_lut;
    localparam int LINE_LEN = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bypass = 0, cfg_indexed = 0, cfg_inband_en = 0;
    logic [11:0] cfg_first_line = 12'd4;
    logic        host_we = 0;
    logic [1:0]  host_sel = 0;
    logic [7:0]  host_addr = 0, host_wdata = 0;
    logic        pix_vld = 0, pix_vs = 0, pix_hs = 0, pix_de = 0;
    logic [23:0] pix_data = 0;
    logic        out_vld, out_vs, out_hs, out_de;
    logic [23:0] out_data;

    logic [7:0] ref_r [256];
    logic [7:0] ref_g [256];
    logic [7:0] ref_b [256];

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rgb_gamma_lut u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_bypass(cfg_bypass), .cfg_indexed(cfg_indexed),
        .cfg_inband_en(cfg_inband_en), .cfg_first_line(cfg_first_line),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
        .host_wdata(host_wdata),
        .pix_vld(pix_vld), .pix_vs(pix_vs), .pix_hs(pix_hs), .pix_de(pix_de),
        .pix_data(pix_data),
        .out_vld(out_vld), .out_vs(out_vs), .out_hs(out_hs), .out_de(out_de),
        .out_data(out_data)
    );

    task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [23:0] expect_px(input logic [23:0] d, input bit idx, input bit byp);
        if (byp) return d;
        if (idx) return {ref_r[d[7:0]], ref_g[d[7:0]], ref_b[d[7:0]]};
        return {ref_r[d[23:16]], ref_g[d[15:8]], ref_b[d[7:0]]};
    endfunction

    // One input cycle; model writes are applied before the expectation (write-first, R8)
    task automatic step(input bit v, input bit vs, input bit hs, input bit de,
                        input logic [23:0] d, input bit hwe, input logic [1:0] hsel,
                        input logic [7:0] ha, input logic [7:0] hd, input string tag);
        logic [3:0]  ef;
        logic [23:0] ed;
        @(negedge clk);
        pix_vld = v; pix_vs = vs; pix_hs = hs; pix_de = de; pix_data = d;
        host_we = hwe; host_sel = hsel; host_addr = ha; host_wdata = hd;
        if (hwe && !cfg_inband_en) begin
            case (hsel)
                2'd0: ref_r[ha] = hd;
                2'd1: ref_g[ha] = hd;
                2'd2: ref_b[ha] = hd;
                default: ;
            endcase
        end
        ef = {v, vs, hs, de};
        ed = expect_px(d, cfg_indexed, cfg_bypass);
        @(posedge clk);
        #2;
        check({tag, " flags (R2)"}, {20'd0, out_vld, out_vs, out_hs, out_de}, {20'd0, ef});
        if (v) check(tag, out_data, ed);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 256; i++) begin
            step(1, 0, 0, 0, {i[7:0], i[7:0], i[7:0]}, 0, 0, 0, 0, tag);
        end
    endtask

    // One frame of first+1 lines; in-band bytes mirrored into the model (R9, R10, R12)
    task automatic frame(input int first, input string tag);
        int cap = 0;
        cfg_first_line = 12'(first);
        for (int l = 0; l <= first; l++) begin
            for (int b = 0; b < LINE_LEN; b++) begin
                logic [23:0] d;
                while ($urandom % 8 == 0) begin
                    step(0, 0, 0, 0, 24'($urandom), 0, 0, 0, 0, "R12 invalid gap");
                end
                d = 24'($urandom);
                if (cfg_inband_en && (l == first - 2 || l == first - 1) && cap < 768) begin
                    case (cap % 3)
                        0: ref_r[cap / 3] = d[7:0];
                        1: ref_g[cap / 3] = d[7:0];
                        default: ref_b[cap / 3] = d[7:0];
                    endcase
                    cap++;
                end
                step(1, (l == 0 && b == 0), (l > 0 && b == 0), (l >= first), d,
                     0, 0, 0, 0, tag);
            end
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [7:0] old;
        seed = $urandom(32'h1F2E3D4C);
        // R1: outputs quiet in reset even with stimulus present
        pix_vld = 1; pix_vs = 1; pix_hs = 1; pix_de = 1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset", {20'd0, out_vld, out_vs, out_hs, out_de}, 24'd0);
        @(negedge clk);
        pix_vld = 0; pix_vs = 0; pix_hs = 0; pix_de = 0;
        rst_n = 1;

        // R6: host load of all three tables
        for (int t = 0; t < 3; t++) begin
            for (int a = 0; a < 256; a++) begin
                step(0, 0, 0, 0, 0, 1, 2'(t), 8'(a), 8'($urandom), "R6 host load");
            end
        end
        // R6: select 3 writes nothing
        step(0, 0, 0, 0, 0, 1, 2'd3, 8'h21, 8'hA5, "R6 sel3 write");
        step(1, 0, 0, 0, 24'h212121, 0, 0, 0, 0, "R6 sel3 ignored");

        // R3: per-channel lookup, random pixels and random flags
        for (int i = 0; i < 400; i++) begin
            step(1, $urandom % 2, $urandom % 2, $urandom % 2, 24'($urandom), 0, 0, 0, 0, "R3 lookup");
        end
        step(1, 0, 0, 1, 24'h00FF00, 0, 0, 0, 0, "R3 corner 00/ff");
        step(1, 0, 0, 1, 24'hFF00FF, 0, 0, 0, 0, "R3 corner ff/00");

        // R4: indexed colour
        cfg_indexed = 1;
        for (int i = 0; i < 200; i++) begin
            step(1, 0, 0, 1, 24'($urandom), 0, 0, 0, 0, "R4 indexed");
        end
        // R5: bypass wins over indexed
        cfg_bypass = 1;
        for (int i = 0; i < 100; i++) begin
            step(1, 0, 0, 1, 24'($urandom), 0, 0, 0, 0, "R5 bypass");
        end
        cfg_bypass = 0;
        cfg_indexed = 0;

        // R8: same-cycle write and lookup of one entry
        step(1, 0, 0, 1, 24'h40_11_22, 1, 2'd0, 8'h40, 8'h9C, "R8 collision red");
        step(1, 0, 0, 1, 24'h33_77_55, 1, 2'd1, 8'h77, 8'h3E, "R8 collision green");
        step(1, 0, 0, 1, 24'h33_77_55, 1, 2'd2, 8'h56, 8'h01, "R8 neighbour entry");
        step(1, 0, 0, 1, 24'h33_77_56, 0, 0, 0, 0, "R8 neighbour readback");

        // R7: host writes ignored while in-band loading is selected
        cfg_inband_en = 1;
        old = ref_r[8'h05];
        step(0, 0, 0, 0, 0, 1, 2'd0, 8'h05, ~old, "R7 host write in-band mode");
        step(1, 0, 0, 0, 24'h050505, 0, 0, 0, 0, "R7 host write ignored");

        // R9/R10: in-band frame, capture spans lines 2 and 3, stops mid line 3
        frame(4, "R9 in-band frame");
        sweep("R10 in-band contents");
        // R9: window opening on the frame-start sample itself
        frame(2, "R9 window at line 0");
        cfg_indexed = 1;
        sweep("R9 in-band contents indexed");
        cfg_indexed = 0;

        // R11: host mode, stream contents must not load
        cfg_inband_en = 0;
        frame(3, "R11 host-mode frame");
        sweep("R11 tables unchanged");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule